// File: doc/BRIEF.md
# Two-Vector Switching-State Sequencer

This block drives the three upper-switch gate bits of a three-phase bridge for one control period at a time. Each period applies two active switching states in sequence. The first state is held for a programmed number of clock ticks. The second state covers the rest of the period. The two all-equal leg states (every leg low or every leg high) are never produced, which keeps the common-mode voltage at one sixth of the bus voltage.

A controller pulses `period_start` once per period and presents a first index, a second index and a first-interval length. These values are captured at the pulse but are applied only from the following pulse onward. This gives one period of delay, which leaves a full period for the next choice to be computed.

An index outside the active range is flagged. In its place the sequencer keeps the state it was driving when the bad value was captured. A tick counter restarts on every pulse. If a pulse arrives late, the counter stops at its last value, so the second state simply continues.

Top module: `twovec_seq`

## Requirements
- R1: After reset, `gate_o` is 3'b100 (index 1) and `idx_err_o` is 0. This holds until the values captured by the first `period_start` are applied at the second `period_start`.
- R2: Index to gate mapping, with `gate_o` = {leg a, leg b, leg c} and 1 meaning the upper switch is closed: 1→100, 2→110, 3→010, 4→011, 5→001, 6→101.
- R3: `gate_o` is never 3'b000 or 3'b111.
- R4: Counting the clock edge of a `period_start` as tick 0, the first index is driven for ticks 0..T1-1 with `phase_o`=0. The second index is driven from tick T1 until the next `period_start` with `phase_o`=1.
- R5: The captured first-interval value t is clamped to T1 = 1 when t = 0 and to T1 = TS-1 when t ≥ TS. Otherwise T1 = t.
- R6: Indices and length sampled at a `period_start` take effect at the next `period_start`, and stay fixed for that whole period.
- R7: At a `period_start` where either input index is 0 or 7, `idx_err_o` becomes 1 from the following cycle until the next `period_start`. Each illegal slot is replaced by the index being driven in the cycle of that `period_start`.
- R8: When the first and second indices are equal, `gate_o` stays constant over the whole period. `phase_o` still changes at tick T1.
- R9: If no `period_start` arrives within TS ticks, the tick counter stops at TS-1 and the second index stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start | input | 1 | One-cycle pulse marking a period boundary |
| first_idx | input | 3 | Index of the first state for the period after next |
| second_idx | input | 3 | Index of the second state for the period after next |
| first_ticks | input | TW | Requested first-interval length in clock ticks |
| gate_o | output | 3 | Upper-switch gate bits {a, b, c} |
| phase_o | output | 1 | 0 while the first state is driven, 1 for the second |
| idx_err_o | output | 1 | An illegal index was captured at the last boundary |

## Verification
The bench builds the sequencer with TS = 8, which makes the length input four bits wide. With that setting, every pair of the eight index codes can be crossed with length values both below and above the legal window. Every length value from 0 to 15 is also swept against a fixed pair. Periods that are shorter and longer than TS exercise early boundaries and counter saturation.

// File: rtl/twovec_pkg.sv
package twovec_pkg;
    typedef logic [2:0] vidx_t;
    typedef logic [2:0] legs_t;

    function automatic legs_t legs_of(input vidx_t idx);
        legs_t l;
        case (idx)
            3'd1:    l = 3'b100;
            3'd2:    l = 3'b110;
            3'd3:    l = 3'b010;
            3'd4:    l = 3'b011;
            3'd5:    l = 3'b001;
            3'd6:    l = 3'b101;
            default: l = 3'b100;
        endcase
        return l;
    endfunction

    function automatic logic is_active(input vidx_t idx);
        return (idx != 3'd0) && (idx != 3'd7);
    endfunction
endpackage

// File: rtl/twovec_vec_decode.sv
module twovec_vec_decode
    import twovec_pkg::*;
(
    input  logic [2:0] idx_i,
    output logic [2:0] legs_o,
    output logic       legal_o
);
    always_comb begin
        legs_o  = legs_of(idx_i);
        legal_o = is_active(idx_i);
    end
endmodule

// File: rtl/twovec_dur_clamp.sv
module twovec_dur_clamp #(
    parameter int TS = 200,
    parameter int TW = $clog2(TS) + 1,
    localparam int CW = $clog2(TS)
) (
    input  logic [TW-1:0] ticks_i,
    output logic [CW-1:0] t1_o
);
    always_comb begin
        if (ticks_i == '0)
            t1_o = CW'(1);
        else if (ticks_i >= TW'(TS))
            t1_o = CW'(TS - 1);
        else
            t1_o = ticks_i[CW-1:0];
    end
endmodule

// File: rtl/twovec_seq.sv
module twovec_seq
    import twovec_pkg::*;
#(
    parameter int TS = 200,
    parameter int TW = $clog2(TS) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          period_start,
    input  logic [2:0]    first_idx,
    input  logic [2:0]    second_idx,
    input  logic [TW-1:0] first_ticks,
    output logic [2:0]    gate_o,
    output logic          phase_o,
    output logic          idx_err_o
);
    localparam int CW = $clog2(TS);
    localparam int NSLOT = 2;

    typedef struct packed {
        vidx_t         cur_a;
        vidx_t         cur_b;
        logic [CW-1:0] cur_t1;
        vidx_t         pend_a;
        vidx_t         pend_b;
        logic [CW-1:0] pend_t1;
        logic [CW-1:0] cnt;
        logic          err;
    } seq_st_t;

    seq_st_t st_d, st_q;

    vidx_t         in_idx   [NSLOT];
    logic [2:0]    in_legs  [NSLOT];
    logic          in_legal [NSLOT];
    logic [CW-1:0] t1_clamped;
    vidx_t         sel_idx;
    logic          in_second;
    logic [2:0]    out_legs;
    logic          out_legal;

    assign in_idx[0] = first_idx;
    assign in_idx[1] = second_idx;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        twovec_vec_decode u_dec (
            .idx_i   (in_idx[s]),
            .legs_o  (in_legs[s]),
            .legal_o (in_legal[s])
        );
    end

    twovec_dur_clamp #(.TS(TS), .TW(TW)) u_clamp (
        .ticks_i (first_ticks),
        .t1_o    (t1_clamped)
    );

    assign in_second = (st_q.cnt >= st_q.cur_t1);
    assign sel_idx   = in_second ? st_q.cur_b : st_q.cur_a;

    twovec_vec_decode u_out_dec (
        .idx_i   (sel_idx),
        .legs_o  (out_legs),
        .legal_o (out_legal)
    );

    always_comb begin
        st_d = st_q;
        if (period_start) begin
            st_d.cnt     = '0;
            st_d.cur_a   = st_q.pend_a;
            st_d.cur_b   = st_q.pend_b;
            st_d.cur_t1  = st_q.pend_t1;
            st_d.pend_a  = in_legal[0] ? in_idx[0] : sel_idx;
            st_d.pend_b  = in_legal[1] ? in_idx[1] : sel_idx;
            st_d.pend_t1 = t1_clamped;
            st_d.err     = !(in_legal[0] && in_legal[1]);
        end else if (st_q.cnt != CW'(TS - 1)) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cur_a   <= 3'd1;
            st_q.cur_b   <= 3'd1;
            st_q.cur_t1  <= CW'(1);
            st_q.pend_a  <= 3'd1;
            st_q.pend_b  <= 3'd1;
            st_q.pend_t1 <= CW'(1);
            st_q.cnt     <= '0;
            st_q.err     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o    = out_legal ? out_legs : 3'b100;
    assign phase_o   = in_second;
    assign idx_err_o = st_q.err;
endmodule

// File: rtl/twovec_seq_chk.sv
module twovec_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       period_start,
    input logic [2:0] gate_o,
    input logic       phase_o,
    input logic       idx_err_o
);
    assert_no_zero_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o != 3'b000) && (gate_o != 3'b111));

    assert_first_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !phase_o);

    assert_second_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o && !period_start) |=> phase_o);

    assert_err_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(idx_err_o));

    assert_gate_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_start && !phase_o) |=> ($stable(gate_o) || phase_o));
endmodule

bind twovec_seq twovec_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .gate_o       (gate_o),
    .phase_o      (phase_o),
    .idx_err_o    (idx_err_o)
);

// File: tb/test_twovec_seq.sv
module test_twovec_seq;
    localparam int CLK_NS = 10;
    localparam int TS = 8;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          period_start = 1'b0;
    logic [2:0]    first_idx = 3'd0;
    logic [2:0]    second_idx = 3'd0;
    logic [TW-1:0] first_ticks = '0;
    logic [2:0]    gate_o;
    logic          phase_o;
    logic          idx_err_o;

    int total = 0;
    int bad = 0;

    int m_ca, m_cb, m_pa, m_pb, m_ct1, m_pt1, m_cnt;
    bit m_err;

    always #(CLK_NS / 2) clk = ~clk;

    twovec_seq #(.TS(TS), .TW(TW)) i_twovec_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .first_idx    (first_idx),
        .second_idx   (second_idx),
        .first_ticks  (first_ticks),
        .gate_o       (gate_o),
        .phase_o      (phase_o),
        .idx_err_o    (idx_err_o)
    );

    // R2 table, {a,b,c}
    function automatic logic [2:0] exp_legs(input int idx);
        case (idx)
            1: return 3'b100;
            2: return 3'b110;
            3: return 3'b010;
            4: return 3'b011;
            5: return 3'b001;
            6: return 3'b101;
            default: return 3'bxxx;
        endcase
    endfunction

    function automatic bit legal(input int idx);
        return idx >= 1 && idx <= 6;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input bit st, input string req);
        int sel;
        period_start = st;
        @(posedge clk);
        sel = (m_cnt >= m_ct1) ? m_cb : m_ca;
        if (st) begin
            m_ca = m_pa; m_cb = m_pb; m_ct1 = m_pt1;
            m_pa = legal(int'(first_idx)) ? int'(first_idx) : sel;
            m_pb = legal(int'(second_idx)) ? int'(second_idx) : sel;
            if (first_ticks == 0) m_pt1 = 1;
            else if (int'(first_ticks) >= TS) m_pt1 = TS - 1;
            else m_pt1 = int'(first_ticks);
            m_err = !(legal(int'(first_idx)) && legal(int'(second_idx)));
            m_cnt = 0;
        end else if (m_cnt < TS - 1) begin
            m_cnt++;
        end
        @(negedge clk);
        period_start = 1'b0;
        sel = (m_cnt >= m_ct1) ? m_cb : m_ca;
        chk(req, "gate", int'(gate_o), int'(exp_legs(sel)));
        chk(req, "phase", int'(phase_o), int'(m_cnt >= m_ct1));
        chk("R7", "err", int'(idx_err_o), int'(m_err));
        chk("R3", "zero-state", int'(gate_o == 3'b000 || gate_o == 3'b111), 0);
    endtask

    task automatic period(input int a, input int b, input int t, input int len, input string req);
        first_idx = 3'(a);
        second_idx = 3'(b);
        first_ticks = TW'(t);
        tick(1'b1, req);
        for (int i = 1; i < len; i++) tick(1'b0, req);
    endtask

    initial begin
        #(CLK_NS * 150000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_ca = 1; m_cb = 1; m_pa = 1; m_pb = 1; m_ct1 = 1; m_pt1 = 1; m_cnt = 0; m_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "gate", int'(gate_o), 3'b100);
        chk("R1", "err", int'(idx_err_o), 0);
        chk("R1", "phase", int'(phase_o), 0);
        for (int i = 0; i < 3; i++) tick(1'b0, "R1");
        // R6: first captured pair not applied during the first period
        period(3, 5, 4, TS, "R6");
        chk("R6", "gate-held", int'(gate_o), 3'b100);
        period(2, 6, 3, TS, "R6");
        // R2 / R7 / R8: all index pairs with assorted lengths (R5 via out-of-window values)
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                period(a, b, (a * 5 + b * 3) % 16, TS,
                       (!legal(a) || !legal(b)) ? "R7" : (a == b ? "R8" : "R2"));
        // R5: full length sweep
        for (int t = 0; t < 16; t++) period(1, 4, t, TS, "R5");
        // R8: equal pair, gate constant
        period(6, 6, 2, TS, "R8");
        period(6, 6, 5, TS, "R8");
        // R9: late boundary, counter saturates
        period(2, 5, 3, TS + 6, "R9");
        period(3, 4, 2, TS + 4, "R9");
        // R6: early boundaries
        period(5, 1, 6, 3, "R6");
        period(4, 2, 1, 2, "R6");
        period(1, 3, 7, TS, "R6");
        period(1, 3, 7, TS, "R4");
        // R7: illegal right after a legal pair, then recovery
        period(0, 7, 3, TS, "R7");
        period(2, 3, 3, TS, "R7");
        period(2, 3, 3, TS, "R7");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule